// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the byte-level half of an SMBus target that exposes a small file of 16-bit registers. A separate bit engine decodes the wire and raises single-cycle events: a start or repeated start, a stop, an address match with its direction, a received data byte, a request for the next byte to transmit, and the host's acknowledge response to a transmitted byte. The responder answers each received byte with an ACK or NACK decision and supplies each byte the host reads.

A command pointer selects the register. It is loaded by the first byte written after a write-direction address match and survives stops and restarts, so a bare read with no command returns the register chosen last. Command values `0` to `NREG-1` select word registers. The value `NREG` selects a block view: a block read returns a count byte of `2*NREG`, followed by every register, low byte first, in ascending order.

Top module: `smbus_reg_responder`

## Requirements
- R1: The first byte written after a write-direction address match is the command. A value from 0 to NREG (8 by default) is ACKed (ack_out=1) and loaded into the pointer.
- R2: A read-direction address with no command returns the low byte and then the high byte of the register held in the pointer, which is kept from earlier transactions.
- R3: In a write, the first data byte after the command goes to bits 7:0 of the selected register and the second goes to bits 15:8. Both are ACKed.
- R4: A write with a single data byte after the command changes only bits 7:0 of the selected register. Bits 15:8 keep their value.
- R5: A read that follows a command and a repeated start returns bits 7:0 first and then bits 15:8 of the selected register.
- R6: With the pointer at NREG, a read returns the count 2*NREG first. It then returns register 0 low, register 0 high, register 1 low, and so on up to the last register's high byte.
- R7: After the host answers a transmitted byte with NACK (host_nack=1), further byte requests get no response (rd_valid stays 0) until the next start or stop.
- R8: A command byte above NREG is NACKed and leaves the pointer unchanged. Every data byte after it in the same transaction is also NACKed.
- R9: A third or later data byte in a write, and any data byte written while the pointer is NREG, is NACKed and changes no register.
- R10: A stop or a start resets the byte position to zero and keeps the pointer.
- R11: ack_valid is 1 exactly one cycle after each ev_wr_byte. rd_valid is 1 exactly one cycle after an answered ev_rd_req. After reset both are 0 and the pointer is 0.
- R12: A read past the last defined byte (past the high byte of a word, or past the last block byte) returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_addr | input | 1 | Own address matched |
| addr_rd | input | 1 | Direction of the matched address, 1 = read |
| ev_wr_byte | input | 1 | Data byte received from host |
| wr_data | input | 8 | Received byte |
| ev_rd_req | input | 1 | Engine needs the next byte to transmit |
| ev_host_resp | input | 1 | Host acknowledge bit for the last transmitted byte |
| host_nack | input | 1 | 1 when that acknowledge bit was NACK |
| ack_valid | output | 1 | ACK decision valid (one cycle) |
| ack_out | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid | output | 1 | Transmit byte valid (one cycle) |
| rd_data | output | 8 | Byte to transmit |

## Verification
A corrupted pointer shows up on the next bare read: the wrong register's bytes appear in the very first rd_data after the address match. A byte position that is not reset by stop or start shows up as 0xFF, or as the high byte, where a low byte is expected, on the first byte of the following transaction. A lost NACK-done state shows up as a stray rd_valid one cycle after the next request. Wrong write steering shows up only when the register is read back, so every write sweep is followed by a full readback through both the word path and the block path.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_WDATA,
    S_WIGN,
    S_READ,
    S_RDONE
  } srr_state_e;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/srr_regfile.sv
module srr_regfile #(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          we_hi,
  input  logic [IW-1:0] w_idx,
  input  logic [7:0]    w_data,
  input  logic [IW-1:0] r_idx,
  input  logic          r_hi,
  output logic [7:0]    r_byte
);
  logic [7:0] lo_mem [NREG];
  logic [7:0] hi_mem [NREG];

  always_ff @(posedge clk) begin
    if (we && !we_hi) lo_mem[w_idx] <= w_data;
    if (we && we_hi)  hi_mem[w_idx] <= w_data;
  end

  assign r_byte = r_hi ? hi_mem[r_idx] : lo_mem[r_idx];
endmodule

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG),
  localparam int COUNT = 2 * NREG,
  localparam int PSW = $clog2(COUNT + 2) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_addr,
  input  logic          addr_rd,
  input  logic          ev_wr_byte,
  input  logic [7:0]    wr_data,
  input  logic          ev_rd_req,
  input  logic          ev_host_resp,
  input  logic          host_nack,
  output logic          we,
  output logic          we_hi,
  output logic [IW-1:0] w_idx,
  output logic [7:0]    w_data,
  output logic [IW-1:0] r_idx,
  output logic          r_hi,
  input  logic [7:0]    r_byte,
  output logic          ack_valid,
  output logic          ack_out,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);
  localparam logic [7:0]     BLK_CMD = 8'(NREG);
  localparam logic [7:0]     CNT_BYTE = 8'(COUNT);
  localparam logic [PSW-1:0] POS_MAX = PSW'(COUNT + 1);
  localparam logic [PSW-1:0] POS_CNT = PSW'(COUNT);

  srr_state_e     state;
  logic [7:0]     ptr;
  logic [PSW-1:0] pos;
  logic [PSW-1:0] pm1;
  logic           is_blk;
  logic           wr_ok;
  logic [7:0]     tx_byte;

  assign is_blk = (ptr == BLK_CMD);
  assign wr_ok  = (ptr < BLK_CMD) && (pos < PSW'(2));
  assign we     = ev_wr_byte && !ev_stop && !ev_start && !ev_addr &&
                  (state == S_WDATA) && wr_ok;
  assign we_hi  = pos[0];
  assign w_idx  = ptr[IW-1:0];
  assign w_data = wr_data;
  assign pm1    = pos - PSW'(1);

  always_comb begin
    if (is_blk) begin
      r_idx = pm1[IW:1];
      r_hi  = pm1[0];
      if (pos == '0)          tx_byte = CNT_BYTE;
      else if (pos <= POS_CNT) tx_byte = r_byte;
      else                    tx_byte = FILL_BYTE;
    end else begin
      r_idx   = ptr[IW-1:0];
      r_hi    = pos[0];
      tx_byte = (pos < PSW'(2)) ? r_byte : FILL_BYTE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr       <= '0;
      pos       <= '0;
      ack_valid <= 1'b0;
      ack_out   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      ack_valid <= 1'b0;
      rd_valid  <= 1'b0;
      if (ev_stop || ev_start) begin
        state <= S_IDLE;
        pos   <= '0;
      end else if (ev_addr) begin
        pos   <= '0;
        state <= addr_rd ? S_READ : S_CMD;
      end else if (ev_wr_byte) begin
        ack_valid <= 1'b1;
        case (state)
          S_CMD: begin
            if (wr_data <= BLK_CMD) begin
              ptr     <= wr_data;
              ack_out <= 1'b1;
              state   <= S_WDATA;
            end else begin
              ack_out <= 1'b0;
              state   <= S_WIGN;
            end
          end
          S_WDATA: begin
            ack_out <= wr_ok;
            if (pos != POS_MAX) pos <= pos + PSW'(1);
          end
          default: ack_out <= 1'b0;
        endcase
      end else if (ev_rd_req && state == S_READ) begin
        rd_valid <= 1'b1;
        rd_data  <= tx_byte;
        if (pos != POS_MAX) pos <= pos + PSW'(1);
      end else if (ev_host_resp && host_nack && state == S_READ) begin
        state <= S_RDONE;
      end
    end
  end
endmodule

// File: rtl/smbus_reg_responder.sv
module smbus_reg_responder #(
  parameter int NREG = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       addr_rd,
  input  logic       ev_wr_byte,
  input  logic [7:0] wr_data,
  input  logic       ev_rd_req,
  input  logic       ev_host_resp,
  input  logic       host_nack,
  output logic       ack_valid,
  output logic       ack_out,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam int IW = $clog2(NREG);

  logic          we, we_hi, r_hi;
  logic [IW-1:0] w_idx, r_idx;
  logic [7:0]    w_data, r_byte;

  srr_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr(ev_addr), .addr_rd(addr_rd), .ev_wr_byte(ev_wr_byte),
    .wr_data(wr_data), .ev_rd_req(ev_rd_req), .ev_host_resp(ev_host_resp),
    .host_nack(host_nack), .we(we), .we_hi(we_hi), .w_idx(w_idx),
    .w_data(w_data), .r_idx(r_idx), .r_hi(r_hi), .r_byte(r_byte),
    .ack_valid(ack_valid), .ack_out(ack_out), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  srr_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .we(we), .we_hi(we_hi), .w_idx(w_idx), .w_data(w_data),
    .r_idx(r_idx), .r_hi(r_hi), .r_byte(r_byte)
  );
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int NREG = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_addr,
  input logic       addr_rd,
  input logic       ev_wr_byte,
  input logic [7:0] wr_data,
  input logic       ev_rd_req,
  input logic       ev_host_resp,
  input logic       host_nack,
  input logic       ack_valid,
  input logic       ack_out,
  input logic       rd_valid
);
  logic cmd_phase, nacked;
  logic plain_wr;
  assign plain_wr = ev_wr_byte && !ev_start && !ev_stop && !ev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_phase <= 1'b0;
      nacked    <= 1'b0;
    end else begin
      if (ev_start || ev_stop) begin
        cmd_phase <= 1'b0;
        nacked    <= 1'b0;
      end else if (ev_addr) begin
        cmd_phase <= !addr_rd;
        nacked    <= 1'b0;
      end else begin
        if (ev_wr_byte) cmd_phase <= 1'b0;
        if (ev_host_resp && host_nack) nacked <= 1'b1;
      end
    end
  end

  // R11: one ACK decision per received byte, one cycle later
  p_ack_follows_byte_r11: assert property (@(posedge clk) disable iff (rst)
    plain_wr |=> ack_valid);
  p_ack_only_after_byte_r11: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ev_wr_byte));
  p_rd_only_after_req_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(ev_rd_req));
  // R8: out-of-range command refused
  p_bad_cmd_nack_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_phase && plain_wr && wr_data > 8'(NREG)) |=> (ack_valid && !ack_out));
  // R1: in-range command accepted
  p_good_cmd_ack_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_phase && plain_wr && wr_data <= 8'(NREG)) |=> (ack_valid && ack_out));
  // R7: silence after host NACK
  p_silent_after_nack_r7: assert property (@(posedge clk) disable iff (rst)
    (nacked && ev_rd_req && !ev_start && !ev_stop && !ev_addr) |=> !rd_valid);
endmodule

bind smbus_reg_responder srr_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_addr(ev_addr), .addr_rd(addr_rd), .ev_wr_byte(ev_wr_byte),
  .wr_data(wr_data), .ev_rd_req(ev_rd_req), .ev_host_resp(ev_host_resp),
  .host_nack(host_nack), .ack_valid(ack_valid), .ack_out(ack_out),
  .rd_valid(rd_valid)
);

// File: tb/sim_smbus_reg_responder.sv
module sim_smbus_reg_responder;
  localparam int NREG = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic ev_start = 0, ev_stop = 0, ev_addr = 0, addr_rd = 0, ev_wr_byte = 0;
  logic ev_rd_req = 0, ev_host_resp = 0, host_nack = 0;
  logic [7:0] wr_data = '0;
  logic ack_valid, ack_out, rd_valid;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] m_lo [NREG];
  logic [7:0] m_hi [NREG];

  always #2.5 clk = ~clk;

  smbus_reg_responder #(.NREG(NREG)) u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(); @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk) ev_stop = 1;  @(negedge clk) ev_stop = 0;  endtask
  task automatic addr(input bit rd);
    @(negedge clk) ev_addr = 1; addr_rd = rd;
    @(negedge clk) ev_addr = 0;
  endtask
  task automatic wbyte(input logic [7:0] d, input bit exp_ack, input string tag);
    @(negedge clk) ev_wr_byte = 1; wr_data = d;
    @(negedge clk) ev_wr_byte = 0;
    check(ack_valid && ack_out == exp_ack, tag, {ack_valid, ack_out}, {1'b1, exp_ack});
  endtask
  task automatic rreq(input bit exp_v, input logic [7:0] exp_d, input string tag);
    @(negedge clk) ev_rd_req = 1;
    @(negedge clk) ev_rd_req = 0;
    if (exp_v) check(rd_valid && rd_data == exp_d, tag, {rd_valid, rd_data}, {1'b1, exp_d});
    else       check(!rd_valid, tag, rd_valid, 0);
  endtask
  task automatic hresp(input bit nack);
    @(negedge clk) ev_host_resp = 1; host_nack = nack;
    @(negedge clk) ev_host_resp = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!ack_valid && !rd_valid, "R11 reset outputs", {ack_valid, rd_valid}, 0);
    // R11: pointer resets to 0; bytes of reg 0 unknown, so only validity is checked
    addr(1);
    @(negedge clk) ev_rd_req = 1;
    @(negedge clk) ev_rd_req = 0;
    check(rd_valid, "R11 bare read answered after reset", rd_valid, 1);
    pulse_stop();
    // R1 R3 R9: write every register as a word, then a refused third byte
    for (int i = 0; i < NREG; i++) begin
      m_lo[i] = 8'((i * 37 + 11) & 255);
      m_hi[i] = 8'((i * 91 + 200) & 255);
      pulse_start(); addr(0);
      wbyte(8'(i), 1, "R1 command accepted");
      wbyte(m_lo[i], 1, "R3 low byte ack");
      wbyte(m_hi[i], 1, "R3 high byte ack");
      wbyte(8'hEE, 0, "R9 third byte nack");
      @(negedge clk);
      check(!ack_valid, "R11 ack one cycle only", ack_valid, 0);
      pulse_stop();
    end
    // R5 R12 R7: combined read of each word
    for (int i = 0; i < NREG; i++) begin
      pulse_start(); addr(0); wbyte(8'(i), 1, "R1 command");
      pulse_start(); addr(1);
      rreq(1, m_lo[i], "R5 low first"); hresp(0);
      rreq(1, m_hi[i], "R5 high second"); hresp(0);
      rreq(1, 8'hFF, "R12 past word"); hresp(1);
      rreq(0, 8'h00, "R7 silent after nack");
      pulse_stop();
    end
    // R2: bare read uses pointer from earlier transaction
    pulse_start(); addr(1);
    rreq(1, m_lo[NREG-1], "R2 bare read low"); hresp(0);
    rreq(1, m_hi[NREG-1], "R2 bare read high"); hresp(1);
    pulse_stop();
    // R10: pointer kept across stop, position reset
    pulse_start(); addr(0); wbyte(8'd2, 1, "R1 command"); pulse_stop();
    pulse_start(); addr(1);
    rreq(1, m_lo[2], "R10 position reset, pointer kept"); hresp(0);
    pulse_start(); addr(1);
    rreq(1, m_lo[2], "R10 restart resets position"); hresp(1);
    pulse_stop();
    // R4: single data byte changes only low byte
    for (int i = 0; i < NREG; i++) begin
      m_lo[i] = m_lo[i] ^ 8'h5A;
      pulse_start(); addr(0); wbyte(8'(i), 1, "R1 command");
      wbyte(m_lo[i], 1, "R4 single byte ack"); pulse_stop();
    end
    for (int i = 0; i < NREG; i++) begin
      pulse_start(); addr(0); wbyte(8'(i), 1, "R1 command");
      pulse_start(); addr(1);
      rreq(1, m_lo[i], "R4 low updated"); hresp(0);
      rreq(1, m_hi[i], "R4 high kept"); hresp(1);
      pulse_stop();
    end
    // R6 R12: block read
    pulse_start(); addr(0); wbyte(8'(NREG), 1, "R1 block command");
    pulse_start(); addr(1);
    rreq(1, 8'(2 * NREG), "R6 count byte"); hresp(0);
    for (int k = 0; k < 2 * NREG; k++) begin
      rreq(1, k[0] ? m_hi[k/2] : m_lo[k/2], "R6 block byte"); hresp(0);
    end
    rreq(1, 8'hFF, "R12 past block"); hresp(1);
    rreq(0, 8'h00, "R7 block silent after nack");
    pulse_stop();
    // R9: data to the block command refused and discarded
    pulse_start(); addr(0); wbyte(8'(NREG), 1, "R1 block command");
    wbyte(8'h00, 0, "R9 block write nack"); pulse_stop();
    // R8: sweep every out-of-range command
    pulse_start(); addr(0); wbyte(8'd3, 1, "R1 command"); pulse_stop();
    for (int c = NREG + 1; c < 256; c++) begin
      pulse_start(); addr(0);
      wbyte(8'(c), 0, "R8 bad command nack");
      if (c % 32 == 0) wbyte(8'h77, 0, "R8 data after bad command nack");
      pulse_stop();
    end
    pulse_start(); addr(1);
    rreq(1, m_lo[3], "R8 pointer unchanged"); hresp(0);
    rreq(1, m_hi[3], "R9 register not disturbed"); hresp(1);
    pulse_stop();
    // R11: request outside a read gets no answer
    rreq(0, 8'h00, "R11 idle request ignored");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule